// File: doc/BRIEF.md
# Multi-Lane Deskew and Fixed-Latency Release Buffer

This block sits after the character decoders of a multi-lane serial converter link. Each lane delivers one decoded octet per clock, plus a flag that marks control characters. A lane's octets are stored only from the control character that opens its initial lane alignment sequence. Anything that arrives earlier is discarded, including other control characters. Every lane has its own small FIFO. That FIFO absorbs the arrival skew between lanes, which can be up to 31 frames.

The block keeps a local multiframe counter that divides the device clock. An external SYSREF rising edge re-phases this counter. The FIFOs are read out together only when all three of these conditions hold:

- every lane has seen its start character;
- a multiframe boundary has passed;
- a programmable number of frames has elapsed after that boundary.

The readout moment therefore depends only on the boundary grid and not on when the lanes happened to arrive. This gives a deterministic latency. A lane that has not yet started holds the release back for as long as it stays silent. If a lane's FIFO fills before the release, the block raises a sticky alignment error and sends a one-cycle resynchronization request.

Top module: `lane_deskew_release`

## Requirements
- R1: In the first cycle after reset is released, `tx_valid`, `align_err` and `resync_req` are 0, `lmfc_tick` is 1, and `tx_data` is all zeros.
- R2: While SYSREF shows no rising edge, `lmfc_tick` is high for one cycle out of every `LMFC_DIV` (16) cycles.
- R3: SYSREF high in cycle c after being low (a rising edge) puts the next `lmfc_tick` in cycle c+1+`LMFC_DIV`, with no tick in between. SYSREF held high does not re-phase the counter again. An edge whose cycle c+1 is already a boundary leaves the tick schedule unchanged.
- R4: A lane starts storing octets at the start character: control flag 1 with code 0x1C. Octets before it are dropped, whether they are control characters with other codes or 0x1C with the flag at 0. The first word read out carries 0x1C on every lane.
- R5: Lane L occupies bits [8L+7:8L] of `rx_data` and `tx_data`. Each word read out holds, for every lane, the octet at the same position counted from that lane's start character, for lane skews of up to 31 cycles.
- R6: Let m be the cycle in which the last lane presents its start character. Let b be the first cycle at or after m+2 in which `lmfc_tick` is high. The first `tx_valid` cycle is b+`rel_dly`+1.
- R7: While any lane has not seen its start character, `tx_valid` stays 0 and nothing is read out.
- R8: Once released, `tx_valid` stays high every cycle and one word leaves per cycle, so every stored word is delivered in order.
- R9: If a lane already holds `DEPTH` (64) octets and receives another before release, `align_err` rises. For a lane writing every cycle from its start character in cycle m, this happens in cycle m+`DEPTH`+1. `align_err` then stays high and `tx_valid` stays 0.
- R10: `resync_req` is high for exactly the one cycle in which `align_err` first goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sysref | input | 1 | External timing reference; its rising edge re-phases the multiframe counter |
| rel_dly | input | DLY_W (6) | Frames to wait after the chosen boundary before readout |
| rx_data | input | LANES*OCT_W (32) | Decoded octets, one per lane |
| rx_ctrl | input | LANES (4) | Per-lane control-character flag |
| tx_data | output | LANES*OCT_W (32) | Aligned octets; zero when not valid |
| tx_valid | output | 1 | Aligned readout active |
| lmfc_tick | output | 1 | High in the cycle the multiframe counter is at zero |
| align_err | output | 1 | Sticky FIFO overflow flag |
| resync_req | output | 1 | One-cycle request to restart lane alignment |

## Verification
The timing of each result is fixed relative to its stimulus:

- A start character presented in cycle m takes effect at the edge that closes m. The release state machine starts waiting for a boundary two cycles after the last lane's start character.
- A SYSREF edge presented in cycle c passes one sampling register and one edge register. It therefore moves the next tick to c+1+16.
- An overflow is flagged one cycle after the write that would have exceeded 64 entries.

The bench samples every output on the falling clock edge. It uses a cycle counter that it keeps itself and logs each observed tick by cycle number. It then compares the first valid cycle, the tick positions and the error cycle against cycle numbers computed from the stimulus. The output words are checked separately through a scoreboard queue, so their values are checked whatever their timing.

// File: rtl/lalign_pkg.sv
package lalign_pkg;

   // Release sequencing: collect lanes, wait for a boundary, hold off, stream.
   typedef enum logic [1:0] {
      REL_WAIT_LANES = 2'd0,
      REL_WAIT_TICK  = 2'd1,
      REL_HOLD       = 2'd2,
      REL_RUN        = 2'd3
   } rel_state_e;

   localparam logic [7:0] START_CODE_DEFAULT = 8'h1C;

endpackage

// File: rtl/lmfc_tracker.sv
module lmfc_tracker #(
   parameter int DIV         = 16,
   parameter int SREF_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sysref,
   output logic tick
);

   localparam int PW = $clog2(DIV);

   if (DIV < 2) begin : g_bad_div
      $error("lmfc_tracker: DIV must be at least 2");
   end
   if (SREF_STAGES < 1) begin : g_bad_stages
      $error("lmfc_tracker: SREF_STAGES must be at least 1");
   end

   logic          sref_lvl;
   logic          sref_prev;
   logic          sref_rise;
   logic [PW-1:0] phase;

   // Sampling of the reference into the device clock domain.
   if (SREF_STAGES == 1) begin : g_one_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sref_lvl <= 1'b0;
         else        sref_lvl <= sysref;
      end
   end else begin : g_chain
      logic [SREF_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SREF_STAGES-2:0], sysref};
      end
      assign sref_lvl = chain[SREF_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sref_prev <= 1'b0;
      else        sref_prev <= sref_lvl;
   end

   assign sref_rise = sref_lvl & ~sref_prev;

   // A rise marks the current cycle as phase zero, so the next value is one.
   // When the rise lands on a boundary this equals the free-running step.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        phase <= '0;
      else if (sref_rise)                phase <= PW'(1);
      else if (phase == PW'(DIV - 1))    phase <= '0;
      else                               phase <= phase + PW'(1);
   end

   assign tick = (phase == '0);

   // R3: the cycle after a captured rise is never a boundary
   a_r3_rise_rephases: assert property (@(posedge clk) disable iff (!rst_n)
      sref_rise |=> !tick);

   // R2: boundaries are isolated single-cycle pulses
   a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/lane_buf.sv
module lane_buf #(
   parameter int               OCT_W     = 8,
   parameter int               DEPTH     = 64,
   parameter logic [OCT_W-1:0] MARK_CODE = 8'h1C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCT_W-1:0] in_data,
   input  logic             in_ctrl,
   input  logic             rd_en,
   output logic             armed,
   output logic [OCT_W-1:0] head,
   output logic             ovf
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("lane_buf: DEPTH must be at least 2");
   end

   logic [OCT_W-1:0] mem [DEPTH];
   logic [AW-1:0]    wp;
   logic [AW-1:0]    rp;
   logic [CW-1:0]    count;
   logic             armed_q;
   logic             ovf_q;
   logic             mark_seen;
   logic             wr_req;
   logic             full;
   logic             rd_ok;
   logic             wr_ok;

   always_comb begin
      mark_seen = in_ctrl && (in_data == MARK_CODE);
      wr_req    = armed_q || mark_seen;
      full      = (count == CW'(DEPTH));
      rd_ok     = rd_en && (count != '0);
      wr_ok     = wr_req && !ovf_q && (!full || rd_ok);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         if (mark_seen)                   armed_q <= 1'b1;
         if (wr_req && full && !rd_ok)    ovf_q   <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         if (rd_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
         unique case ({wr_ok, rd_ok})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= in_data;
   end

   assign head  = mem[rp];
   assign armed = armed_q;
   assign ovf   = ovf_q;

   // R4: nothing is stored while the lane waits for its start character
   a_r4_no_store_before_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !mark_seen) |=> (count == '0));

   // R9: an overflow stays flagged
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

   // R8: the release logic never reads an empty lane
   a_r8_read_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (count != '0));

endmodule

// File: rtl/release_ctrl.sv
module release_ctrl
   import lalign_pkg::*;
#(
   parameter int DLY_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             all_ready,
   input  logic             tick,
   input  logic             fault,
   input  logic [DLY_W-1:0] rel_dly,
   output logic             run
);

   rel_state_e       st;
   logic [DLY_W-1:0] dcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= REL_WAIT_LANES;
         dcnt <= '0;
      end else begin
         unique case (st)
            REL_WAIT_LANES: if (all_ready) st <= REL_WAIT_TICK;
            REL_WAIT_TICK: begin
               if (tick) begin
                  if (rel_dly == '0) begin
                     st <= REL_RUN;
                  end else begin
                     st   <= REL_HOLD;
                     dcnt <= rel_dly;
                  end
               end
            end
            REL_HOLD: begin
               if (dcnt == DLY_W'(1)) st   <= REL_RUN;
               else                   dcnt <= dcnt - DLY_W'(1);
            end
            REL_RUN: st <= REL_RUN;
            default: st <= REL_WAIT_LANES;
         endcase
      end
   end

   assign run = (st == REL_RUN) && !fault;

   // R7: no readout until every lane has started
   a_r7_wait_for_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      !all_ready |-> !run);

   // R6: with zero delay the stream starts right after a boundary
   a_r6_zero_delay_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(run) && (rel_dly == '0) && $stable(rel_dly)) |-> $past(tick));

endmodule

// File: rtl/lane_deskew_release.sv
module lane_deskew_release
   import lalign_pkg::*;
#(
   parameter int               LANES       = 4,
   parameter int               OCT_W       = 8,
   parameter int               MAX_SKEW    = 32,
   parameter int               LMFC_DIV    = 16,
   parameter int               DEPTH       = 64,
   parameter int               DLY_W       = 6,
   parameter int               SREF_STAGES = 1,
   parameter logic [OCT_W-1:0] MARK_CODE   = START_CODE_DEFAULT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sysref,
   input  logic [DLY_W-1:0]       rel_dly,
   input  logic [LANES*OCT_W-1:0] rx_data,
   input  logic [LANES-1:0]       rx_ctrl,
   output logic [LANES*OCT_W-1:0] tx_data,
   output logic                   tx_valid,
   output logic                   lmfc_tick,
   output logic                   align_err,
   output logic                   resync_req
);

   localparam int BUS_W = LANES * OCT_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("lane_deskew_release: LANES must be at least 1");
   end
   if (DEPTH < MAX_SKEW + LMFC_DIV) begin : g_bad_depth
      $error("lane_deskew_release: DEPTH cannot absorb skew plus one multiframe");
   end

   logic [LANES-1:0] armed;
   logic [LANES-1:0] ovf;
   logic [BUS_W-1:0] heads;
   logic             tick;
   logic             run;
   logic             fault;
   logic             fault_q;

   lmfc_tracker #(
      .DIV         (LMFC_DIV),
      .SREF_STAGES (SREF_STAGES)
   ) u_lmfc (
      .clk    (clk),
      .rst_n  (rst_n),
      .sysref (sysref),
      .tick   (tick)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      lane_buf #(
         .OCT_W     (OCT_W),
         .DEPTH     (DEPTH),
         .MARK_CODE (MARK_CODE)
      ) u_buf (
         .clk     (clk),
         .rst_n   (rst_n),
         .in_data (rx_data[g*OCT_W +: OCT_W]),
         .in_ctrl (rx_ctrl[g]),
         .rd_en   (run),
         .armed   (armed[g]),
         .head    (heads[g*OCT_W +: OCT_W]),
         .ovf     (ovf[g])
      );
   end

   assign fault = |ovf;

   release_ctrl #(
      .DLY_W (DLY_W)
   ) u_rel (
      .clk       (clk),
      .rst_n     (rst_n),
      .all_ready (&armed),
      .tick      (tick),
      .fault     (fault),
      .rel_dly   (rel_dly),
      .run       (run)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault_q <= 1'b0;
      else        fault_q <= fault;
   end

   assign tx_data    = run ? heads : '0;
   assign tx_valid   = run;
   assign lmfc_tick  = tick;
   assign align_err  = fault;
   assign resync_req = fault & ~fault_q;

   // R5: readout only ever happens with every lane locked
   a_r5_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (&armed));

   // R9: the error flag stays up and blocks output
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |=> align_err);
   a_r9_no_data_after_err: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |-> !tx_valid);

   // R10: the resync request is a single pulse
   a_r10_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
      resync_req |=> !resync_req);

endmodule

// File: tb/test_lane_deskew_release.sv
module test_lane_deskew_release;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int  LANES = 4;
   localparam int  OW    = 8;
   localparam int  DIV   = 16;
   localparam int  DEPTH = 64;
   localparam int  DLY_W = 6;
   localparam real TCK   = 8.0;

   logic                clk     = 1'b0;
   logic                rst_n   = 1'b0;
   logic                sysref  = 1'b0;
   logic [DLY_W-1:0]    rel_dly = '0;
   logic [LANES*OW-1:0] rx_data = '0;
   logic [LANES-1:0]    rx_ctrl = '0;
   logic [LANES*OW-1:0] tx_data;
   logic                tx_valid;
   logic                lmfc_tick;
   logic                align_err;
   logic                resync_req;

   always #(TCK / 2.0) clk = ~clk;

   lane_deskew_release i_lane_deskew_release (
      .clk        (clk),
      .rst_n      (rst_n),
      .sysref     (sysref),
      .rel_dly    (rel_dly),
      .rx_data    (rx_data),
      .rx_ctrl    (rx_ctrl),
      .tx_data    (tx_data),
      .tx_valid   (tx_valid),
      .lmfc_tick  (lmfc_tick),
      .align_err  (align_err),
      .resync_req (resync_req)
   );

   int                  checks = 0;
   int                  fails  = 0;
   longint              cyc    = 0;
   bit                  edge_hist [longint];
   longint              first_valid = -1;
   bit                  prev_valid  = 1'b0;
   int                  popped      = 0;
   logic [LANES*OW-1:0] exp_q [$];
   logic [LANES*OW-1:0] exp_w;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [7:0] fval(input int lane, input int idx);
      return 8'(lane * 61 + idx * 7 + 3);
   endfunction

   // Monitor: tick log, first-valid capture, scoreboard pops, continuity.
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_valid = 1'b0;
      end else begin
         if (lmfc_tick) edge_hist[cyc] = 1'b1;
         if (tx_valid) begin
            if (first_valid < 0) first_valid = cyc;
            if (exp_q.size() > 0) begin
               exp_w = exp_q.pop_front();
               chk(tx_data == exp_w, (popped == 0) ? "R4" : "R5",
                   "aligned output word", longint'(tx_data), longint'(exp_w));
               popped++;
            end
         end else if (prev_valid) begin
            chk(1'b0, "R8", "tx_valid dropped after release", 0, 1);
         end
         prev_valid = tx_valid;
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n   = 1'b0;
      sysref  = 1'b0;
      rx_data = '0;
      rx_ctrl = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic bit tick_at(input longint c);
      return edge_hist.exists(c);
   endfunction

   // Driver: drives skewed lane streams and pushes expected aligned words.
   task automatic run_case(input int sk[LANES], input int dly, input int ncyc,
                           input bit idle3, input bit want_ovf);
      int     maxsk;
      int     npush;
      longint s;
      longint b;
      maxsk   = 0;
      rel_dly = DLY_W'(dly);
      do_reset();
      exp_q.delete();
      first_valid = -1;
      popped      = 0;
      for (int l = 0; l < LANES; l++)
         if (!(idle3 && l == LANES - 1) && sk[l] > maxsk) maxsk = sk[l];
      npush = ncyc - maxsk;
      s     = cyc;
      for (int t = 0; t < ncyc; t++) begin
         if (t > 0) @(negedge clk);
         for (int l = 0; l < LANES; l++) begin
            int idx;
            idx = t - sk[l];
            if (idle3 && l == LANES - 1) idx = -1;
            if (idx < 0) begin
               if (t % 2 == 0) begin rx_data[l*OW +: OW] = 8'hBC; rx_ctrl[l] = 1'b1; end
               else            begin rx_data[l*OW +: OW] = 8'h1C; rx_ctrl[l] = 1'b0; end
            end else if (idx == 0) begin
               rx_data[l*OW +: OW] = 8'h1C;
               rx_ctrl[l]          = 1'b1;
            end else begin
               rx_data[l*OW +: OW] = fval(l, idx);
               rx_ctrl[l]          = 1'b0;
            end
         end
         if (!idle3 && !want_ovf && t < npush) begin
            logic [LANES*OW-1:0] w;
            for (int l = 0; l < LANES; l++)
               w[l*OW +: OW] = (t == 0) ? 8'h1C : fval(l, t);
            exp_q.push_back(w);
         end
         if (want_ovf) begin
            if (t == DEPTH)
               chk(align_err == 1'b0, "R9", "align_err before overflow", align_err, 0);
            if (t == DEPTH + 1) begin
               chk(align_err == 1'b1, "R9", "align_err at overflow", align_err, 1);
               chk(resync_req == 1'b1, "R10", "resync_req at overflow", resync_req, 1);
            end
            if (t == DEPTH + 2) begin
               chk(resync_req == 1'b0, "R10", "resync_req after pulse", resync_req, 0);
               chk(align_err == 1'b1, "R9", "align_err held", align_err, 1);
            end
         end
      end
      @(negedge clk);
      rx_data = '0;
      rx_ctrl = '0;
      if (idle3) begin
         chk(first_valid == -1, "R7", "release with an idle lane", first_valid, -1);
         chk(align_err == 1'b0, "R7", "align_err while waiting", align_err, 0);
      end else if (want_ovf) begin
         chk(first_valid == -1, "R9", "output after overflow", first_valid, -1);
      end else begin
         repeat (150) @(negedge clk);
         chk(exp_q.size() == 0, "R8", "words not delivered", exp_q.size(), 0);
         chk(popped == npush, "R8", "words delivered", popped, npush);
         b = s + maxsk + 2;
         for (int k = 0; k < 2 * DIV && !tick_at(b); k++) b++;
         chk(first_valid == b + dly + 1, "R6", "first valid cycle",
             first_valid, b + dly + 1);
      end
   endtask

   initial begin : watchdog
      #(TCK * 200000);
      fails++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      longint r;

      // R1 reset state and R2 free-running period
      do_reset();
      r = cyc;
      chk(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);
      chk(align_err == 1'b0, "R1", "align_err after reset", align_err, 0);
      chk(resync_req == 1'b0, "R1", "resync_req after reset", resync_req, 0);
      chk(lmfc_tick == 1'b1, "R1", "lmfc_tick after reset", lmfc_tick, 1);
      chk(tx_data == '0, "R1", "tx_data after reset", longint'(tx_data), 0);
      repeat (52) @(negedge clk);
      chk(tick_at(r + 16), "R2", "tick at +16", tick_at(r + 16), 1);
      chk(tick_at(r + 32), "R2", "tick at +32", tick_at(r + 32), 1);
      chk(tick_at(r + 48), "R2", "tick at +48", tick_at(r + 48), 1);
      chk(!tick_at(r + 8), "R2", "no tick at +8", tick_at(r + 8), 0);
      chk(!tick_at(r + 24), "R2", "no tick at +24", tick_at(r + 24), 0);

      // R3 SYSREF re-phasing, held level, and edge on a boundary
      do_reset();
      r = cyc;
      for (int t = 1; t <= 100; t++) begin
         @(negedge clk);
         if (t == 4)  sysref = 1'b1;
         if (t == 60) sysref = 1'b0;
         if (t == 68) sysref = 1'b1;
         if (t == 80) sysref = 1'b0;
      end
      chk(!tick_at(r + 16), "R3", "old boundary suppressed", tick_at(r + 16), 0);
      chk(tick_at(r + 21), "R3", "tick moved to c+1+DIV", tick_at(r + 21), 1);
      chk(tick_at(r + 37), "R3", "held high, tick +37", tick_at(r + 37), 1);
      chk(tick_at(r + 53), "R3", "held high, tick +53", tick_at(r + 53), 1);
      chk(!tick_at(r + 45), "R3", "no extra tick while held", tick_at(r + 45), 0);
      chk(tick_at(r + 69), "R3", "boundary under aligned edge", tick_at(r + 69), 1);
      chk(!tick_at(r + 77), "R3", "aligned edge no extra tick", tick_at(r + 77), 0);
      chk(tick_at(r + 85), "R3", "aligned edge keeps schedule", tick_at(r + 85), 1);

      // R4 R5 R6 R8 aligned readout with several skews and delays
      run_case('{0, 5, 12, 31}, 0, 150, 1'b0, 1'b0);
      run_case('{3, 0, 20, 7}, 9, 150, 1'b0, 1'b0);
      run_case('{0, 0, 0, 0}, 2, 100, 1'b0, 1'b0);

      // R7 idle lane holds the release
      run_case('{0, 4, 9, 0}, 0, 40, 1'b1, 1'b0);

      // R9 R10 overflow before release
      run_case('{0, 20, 20, 20}, 63, 120, 1'b0, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule